// File: doc/BRIEF.md
# Card Interface Power Sequencer

This block controls the power state of a memory-card host interface. Software writes a 2-bit power-mode field and a direction-polarity bit through a small register port. From the state it holds, the block decides two things. First, whether it overrides the pads of the card clock, the command line and each data line. Second, which level it drives on those pads. It also produces the enable that lets the rest of the host controller run.

Five named states make up the state machine. RST_HIZ is the state after reset: nothing is driven. PCYCLE drives every line low, so the card cannot draw power through its signal pins. POFF drives every line high while the controller stays disabled. PWAKE releases the clock pad and keeps the command and data lines high while it counts card-clock ticks. PON releases every pad and enables the controller.

The named transitions are:
- Reset puts the block in RST_HIZ.
- Mode 10 leads to PCYCLE from RST_HIZ, POFF, PWAKE or PON.
- Mode 00 leads to POFF from PCYCLE, PWAKE or PON.
- Mode 11 leads to PWAKE, but only from POFF.
- Counting the last start-up tick moves PWAKE to PON.

Every other write leaves the state as it is.

Top module: `card_pwr_seq`

## Requirements
- R1: After reset, every pad output-enable is 0, every drive level is 0, `host_en` is 0 and `reg_rdata` is 000.
- R2: Writing mode 10 (bits [1:0]) from RST_HIZ, POFF, PWAKE or PON enters PCYCLE. In PCYCLE all output-enables are 1, all levels are 0, `host_en` is 0 and readback bits [1:0] are 10.
- R3: Writing mode 00 from PCYCLE, PWAKE or PON enters POFF. In POFF all output-enables are 1, all levels are 1, `host_en` is 0 and readback bits [1:0] are 00.
- R4: Mode 11 is accepted only in POFF. Written in RST_HIZ or PCYCLE, it leaves the state unchanged.
- R5: In PWAKE, `ck_oe` is 0, the command and data lines are enabled and driven high, and readback bits [1:0] are 11. `host_en` stays 0 until the WAKE_CYC-th `card_tick` cycle of the window and is 1 in the cycle after it.
- R6: Cycles without `card_tick` do not advance the start-up count.
- R7: A write that selects the current state is ignored. In particular, mode 11 written in PWAKE does not restart the count, and mode 11 written in PON keeps `host_en` at 1.
- R8: The reserved mode 01 leaves the state unchanged.
- R9: Leaving PWAKE or PON clears the start-up count, so a later entry into PWAKE needs WAKE_CYC fresh ticks.
- R10: Bit 2 of every write sets the direction polarity, which reads back in bit 2. When it is 1, `xcvr_dir_cmd` and `xcvr_dir_dat` are the inverse of `ctl_dir_cmd` and `ctl_dir_dat`; when it is 0 they pass through unchanged.
- R11: In PON all output-enables are 0, `host_en` is 1 and readback bits [1:0] are 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the power register |
| reg_wdata | input | 3 | [1:0] power mode, [2] direction polarity |
| reg_rdata | output | 3 | [1:0] current mode code, [2] direction polarity |
| card_tick | input | 1 | One pulse per card clock cycle while the card clock toggles |
| ctl_dir_cmd | input | 1 | Command-line direction from the host controller |
| ctl_dir_dat | input | 1 | Data-bus direction from the host controller |
| xcvr_dir_cmd | output | 1 | Command direction to the external transceiver |
| xcvr_dir_dat | output | 1 | Data direction to the external transceiver |
| ck_oe | output | 1 | Sequencer override enable for the card clock pad |
| ck_lvl | output | 1 | Level driven on the card clock pad when overridden |
| cmd_oe | output | 1 | Override enable for the command pad |
| cmd_lvl | output | 1 | Level driven on the command pad |
| dat_oe | output | DATA_W | Override enable per data pad |
| dat_lvl | output | DATA_W | Level driven per data pad |
| host_en | output | 1 | Enable for the rest of the host controller |

## Verification
The bench builds the block with its defaults: DATA_W = 8 and WAKE_CYC = 74. The full-width data bus lets the checks cover all eight data pads in the low, high and released cases. The real window length puts the off-by-one edges in reach: 73 ticks against 74, a window interrupted and restarted, and a same-state write part way through a count. Long stretches with no tick show that the count depends on the card clock rather than on the block clock.

// File: rtl/cps_pkg.sv
package cps_pkg;

    typedef enum logic [2:0] {
        RST_HIZ = 3'd0,
        PCYCLE  = 3'd1,
        POFF    = 3'd2,
        PWAKE   = 3'd3,
        PON     = 3'd4
    } pwr_state_e;

    localparam logic [1:0] MODE_OFF   = 2'b00;
    localparam logic [1:0] MODE_RSVD  = 2'b01;
    localparam logic [1:0] MODE_CYCLE = 2'b10;
    localparam logic [1:0] MODE_ON    = 2'b11;

    function automatic logic [1:0] mode_code(pwr_state_e s);
        logic [1:0] c;
        unique case (s)
            PCYCLE:      c = MODE_CYCLE;
            PWAKE, PON:  c = MODE_ON;
            default:     c = MODE_OFF;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/cps_wake_cnt.sv
module cps_wake_cnt #(
    parameter int WAKE_CYC = 74
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic done
);
    localparam int CNT_W = (WAKE_CYC > 2) ? $clog2(WAKE_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WAKE_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run)
            cnt_q <= '0;
        else if (tick && cnt_q != LAST)
            cnt_q <= cnt_q + 1'b1;
    end

    assign done = run && tick && (cnt_q == LAST);

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST); // R5
    AST_CNT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt_q == '0); // R9
    AST_CNT_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> $stable(cnt_q) || cnt_q == '0); // R6

endmodule

// File: rtl/cps_fsm.sv
module cps_fsm
    import cps_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_mode,
    input  logic       wake_done,
    output pwr_state_e state
);
    pwr_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= RST_HIZ;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RST_HIZ: begin
                if (wr_en && wr_mode == MODE_CYCLE) state_d = PCYCLE;
            end
            PCYCLE: begin
                if (wr_en && wr_mode == MODE_OFF) state_d = POFF;
            end
            POFF: begin
                if (wr_en && wr_mode == MODE_CYCLE)   state_d = PCYCLE;
                else if (wr_en && wr_mode == MODE_ON) state_d = PWAKE;
            end
            PWAKE: begin
                if (wr_en && wr_mode == MODE_OFF)        state_d = POFF;
                else if (wr_en && wr_mode == MODE_CYCLE) state_d = PCYCLE;
                else if (wake_done)                      state_d = PON;
            end
            PON: begin
                if (wr_en && wr_mode == MODE_OFF)        state_d = POFF;
                else if (wr_en && wr_mode == MODE_CYCLE) state_d = PCYCLE;
            end
            default: state_d = RST_HIZ;
        endcase
    end

    assign state = state_q;

    AST_WAKE_FROM_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != PWAKE) |=> (state_q != PWAKE) || ($past(state_q) == POFF)); // R4
    AST_RSVD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_mode == MODE_RSVD && !wake_done) |=> $stable(state_q)); // R8
    AST_SAME_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PWAKE && wr_en && wr_mode == MODE_ON) |=> (state_q == PWAKE || state_q == PON)); // R7
    AST_ON_FROM_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != PON) |=> (state_q != PON) || ($past(state_q) == PWAKE)); // R5

endmodule

// File: rtl/cps_pad_ctl.sv
module cps_pad_ctl
    import cps_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  pwr_state_e        state,
    output logic              ck_oe,
    output logic              ck_lvl,
    output logic              cmd_oe,
    output logic              cmd_lvl,
    output logic [DATA_W-1:0] dat_oe,
    output logic [DATA_W-1:0] dat_lvl,
    output logic              host_en
);
    logic line_oe, line_lvl;

    always_comb begin
        ck_oe    = 1'b0;
        ck_lvl   = 1'b0;
        line_oe  = 1'b0;
        line_lvl = 1'b0;
        host_en  = 1'b0;
        unique case (state)
            RST_HIZ: ;
            PCYCLE: begin
                ck_oe   = 1'b1;
                line_oe = 1'b1;
            end
            POFF: begin
                ck_oe    = 1'b1;
                ck_lvl   = 1'b1;
                line_oe  = 1'b1;
                line_lvl = 1'b1;
            end
            PWAKE: begin
                line_oe  = 1'b1;
                line_lvl = 1'b1;
            end
            PON: host_en = 1'b1;
            default: ;
        endcase
    end

    assign cmd_oe  = line_oe;
    assign cmd_lvl = line_lvl;

    for (genvar i = 0; i < DATA_W; i++) begin : g_dat
        assign dat_oe[i]  = line_oe;
        assign dat_lvl[i] = line_lvl;
    end

endmodule

// File: rtl/card_pwr_seq.sv
module card_pwr_seq
    import cps_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int WAKE_CYC = 74
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_wdata,
    output logic [2:0]        reg_rdata,
    input  logic              card_tick,
    input  logic              ctl_dir_cmd,
    input  logic              ctl_dir_dat,
    output logic              xcvr_dir_cmd,
    output logic              xcvr_dir_dat,
    output logic              ck_oe,
    output logic              ck_lvl,
    output logic              cmd_oe,
    output logic              cmd_lvl,
    output logic [DATA_W-1:0] dat_oe,
    output logic [DATA_W-1:0] dat_lvl,
    output logic              host_en
);
    pwr_state_e state;
    logic       wake_done;
    logic       pol_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pol_q <= 1'b0;
        else if (reg_wr)
            pol_q <= reg_wdata[2];
    end

    cps_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr),
        .wr_mode   (reg_wdata[1:0]),
        .wake_done (wake_done),
        .state     (state)
    );

    cps_wake_cnt #(.WAKE_CYC(WAKE_CYC)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == PWAKE),
        .tick  (card_tick),
        .done  (wake_done)
    );

    cps_pad_ctl #(.DATA_W(DATA_W)) u_pad (
        .state   (state),
        .ck_oe   (ck_oe),
        .ck_lvl  (ck_lvl),
        .cmd_oe  (cmd_oe),
        .cmd_lvl (cmd_lvl),
        .dat_oe  (dat_oe),
        .dat_lvl (dat_lvl),
        .host_en (host_en)
    );

    assign reg_rdata    = {pol_q, mode_code(state)};
    assign xcvr_dir_cmd = ctl_dir_cmd ^ pol_q;
    assign xcvr_dir_dat = ctl_dir_dat ^ pol_q;

    AST_EN_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_en) |-> $past(card_tick)); // R6
    AST_LOW_ALL_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        (ck_oe && !ck_lvl) |-> (cmd_oe && !cmd_lvl && (&dat_oe) && !(|dat_lvl))); // R2
    AST_EN_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        host_en |-> (!ck_oe && !cmd_oe && !(|dat_oe))); // R11
    AST_POL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> reg_rdata[2] == $past(reg_wdata[2])); // R10

endmodule

// File: tb/tb_card_pwr_seq.sv
`timescale 1ns/1ps
module tb_card_pwr_seq;
    localparam int DATA_W   = 8;
    localparam int WAKE_CYC = 74;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [2:0] reg_wdata = '0;
    logic [2:0] reg_rdata;
    logic card_tick = 1'b0;
    logic ctl_dir_cmd = 1'b0, ctl_dir_dat = 1'b0;
    logic xcvr_dir_cmd, xcvr_dir_dat;
    logic ck_oe, ck_lvl, cmd_oe, cmd_lvl, host_en;
    logic [DATA_W-1:0] dat_oe, dat_lvl;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    card_pwr_seq #(.DATA_W(DATA_W), .WAKE_CYC(WAKE_CYC)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .card_tick(card_tick),
        .ctl_dir_cmd(ctl_dir_cmd), .ctl_dir_dat(ctl_dir_dat),
        .xcvr_dir_cmd(xcvr_dir_cmd), .xcvr_dir_dat(xcvr_dir_dat),
        .ck_oe(ck_oe), .ck_lvl(ck_lvl), .cmd_oe(cmd_oe), .cmd_lvl(cmd_lvl),
        .dat_oe(dat_oe), .dat_lvl(dat_lvl), .host_en(host_en)
    );

    // vector: {req[3:0], mode[1:0], pol, exp_rdata[2:0], exp_ck_oe, exp_ck_lvl, exp_line_oe, exp_line_lvl, exp_en}
    localparam int NV = 12;
    localparam logic [14:0] VEC [NV] = '{
        {4'd4,  2'b11, 1'b0, 3'b000, 5'b00000},  // R4 on from reset ignored
        {4'd8,  2'b01, 1'b0, 3'b000, 5'b00000},  // R8 reserved
        {4'd7,  2'b00, 1'b0, 3'b000, 5'b00000},  // R7 same encoding as reset
        {4'd2,  2'b10, 1'b0, 3'b010, 5'b10100},  // R2 cycle
        {4'd4,  2'b11, 1'b0, 3'b010, 5'b10100},  // R4 on from cycle ignored
        {4'd8,  2'b01, 1'b1, 3'b110, 5'b10100},  // R8 reserved, R10 pol set
        {4'd3,  2'b00, 1'b1, 3'b100, 5'b11110},  // R3 off
        {4'd10, 2'b01, 1'b0, 3'b000, 5'b11110},  // R10 pol clear
        {4'd5,  2'b11, 1'b0, 3'b011, 5'b00110},  // R5 wake
        {4'd2,  2'b10, 1'b0, 3'b010, 5'b10100},  // R2 cycle from wake
        {4'd3,  2'b00, 1'b0, 3'b000, 5'b11110},  // R3 off
        {4'd5,  2'b11, 1'b0, 3'b011, 5'b00110}   // R5 wake again
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] mode, input logic pol);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = {pol, mode};
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            card_tick = 1'b1;
            @(negedge clk);
            card_tick = 1'b0;
        end
    endtask

    function automatic logic [4:0] pads();
        logic lo, ll;
        lo = (cmd_oe  && (&dat_oe))  ? 1'b1 : ((!cmd_oe  && !(|dat_oe))  ? 1'b0 : 1'bx);
        ll = (cmd_lvl && (&dat_lvl)) ? 1'b1 : ((!cmd_lvl && !(|dat_lvl)) ? 1'b0 : 1'bx);
        return {ck_oe, ck_lvl, lo, ll, host_en};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        check("R1 pads/enable at reset", {27'd0, pads()}, 32'd0);
        check("R1 readback at reset", {29'd0, reg_rdata}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 pads after release", {27'd0, pads()}, 32'd0);

        for (int v = 0; v < NV; v++) begin
            wr_reg(VEC[v][10:9], VEC[v][8]);
            check($sformatf("R%0d vector %0d readback", VEC[v][14:11], v),
                  {29'd0, reg_rdata}, {29'd0, VEC[v][7:5]});
            check($sformatf("R%0d vector %0d pads", VEC[v][14:11], v),
                  {27'd0, pads()}, {27'd0, VEC[v][4:0]});
        end

        // now in PWAKE with a fresh count
        repeat (100) @(negedge clk);
        check("R6 no ticks keeps controller off", {31'd0, host_en}, 32'd0);
        ticks(WAKE_CYC - 1);
        check("R5 enable low after WAKE_CYC-1 ticks", {31'd0, host_en}, 32'd0);
        check("R5 command and data high in wake", {27'd0, pads()}, 32'b00110);
        ticks(1);
        check("R5 enable after WAKE_CYC ticks", {31'd0, host_en}, 32'd1);
        check("R11 pads released in on", {27'd0, pads()}, 32'b00001);
        check("R11 readback in on", {29'd0, reg_rdata}, 32'b011);

        wr_reg(2'b11, 1'b0);
        check("R7 on written in on keeps enable", {31'd0, host_en}, 32'd1);

        // R7: same-state write mid-window does not restart
        wr_reg(2'b00, 1'b0);
        check("R3 off from on", {27'd0, pads()}, 32'b11110);
        wr_reg(2'b11, 1'b0);
        ticks(40);
        wr_reg(2'b11, 1'b0);
        ticks(WAKE_CYC - 41);
        check("R7 no restart, still one tick short", {31'd0, host_en}, 32'd0);
        ticks(1);
        check("R7 no restart, enable on time", {31'd0, host_en}, 32'd1);

        // R9: interrupted window clears the count
        wr_reg(2'b00, 1'b0);
        wr_reg(2'b11, 1'b0);
        ticks(50);
        wr_reg(2'b00, 1'b0);
        wr_reg(2'b11, 1'b0);
        ticks(WAKE_CYC - 1);
        check("R9 count cleared on leaving wake", {31'd0, host_en}, 32'd0);
        ticks(1);
        check("R9 full window after re-entry", {31'd0, host_en}, 32'd1);

        // R10 direction polarity
        ctl_dir_cmd = 1'b1;
        ctl_dir_dat = 1'b0;
        wr_reg(2'b11, 1'b1);
        check("R10 polarity readback", {29'd0, reg_rdata}, 32'b111);
        check("R10 inverted directions", {30'd0, xcvr_dir_cmd, xcvr_dir_dat}, 32'b01);
        wr_reg(2'b01, 1'b0);
        check("R10 pass-through directions", {30'd0, xcvr_dir_cmd, xcvr_dir_dat}, 32'b10);
        check("R8 reserved keeps on", {31'd0, host_en}, 32'd1);

        // R1 reset from on
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset from on pads", {27'd0, pads()}, 32'd0);
        check("R1 reset from on readback", {29'd0, reg_rdata}, 32'd0);
        check("R1 dat_oe all zero", {{(32-DATA_W){1'b0}}, dat_oe}, 32'd0);

        finished = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!finished && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<20000", cyc);
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule